// File: doc/BRIEF.md
# Guest Instruction Intercept Decision Unit

This unit sits beside the decode and event logic of a processor core running guest software under a hypervisor. For each instruction or event it is handed, it returns one verdict from a fixed set of five. The instruction or event proceeds normally, raises an undefined-opcode fault, raises a general-protection fault, raises a not-present fault, or forces an exit to the hypervisor. It handles five request kinds. Two are the supervisor-state save and restore instructions, and one is an attempted task switch. The other two are an arriving external interrupt and an arriving non-maskable interrupt.

For save and restore, the unit ANDs three 64-bit masks bit by bit and ORs the result down to one bit. The masks are the requested-component mask, the supervisor-state enable register and the hypervisor's exiting bitmap. An enable control gates this test, and with the enable off both instructions fault as undefined. Every task-switch attempt must first pass the gate checks, in a fixed order, before its unconditional exit can apply. The interrupt kinds exit when their exiting controls are set. The guest's interrupt-enable flag does not affect that exit. A parameter per kind decides whether an interrupt shadow after an interrupt-enable or stack-segment load holds the exit back.

The verdict is registered. A one-cycle valid pulse accompanies it, one clock after the request strobe.

Top module: `guest_intercept_decider`

## Requirements
- R1: While reset is asserted (rstN low), outValid is 0 and verdict is 5'b00000, even when inValid is high.
- R2: outValid is high in exactly the cycle after each cycle with inValid high, and low otherwise. Verdict is one-hot with bit 0 NORMAL, bit 1 UD_FAULT, bit 2 GP_FAULT, bit 3 NP_FAULT and bit 4 VM_EXIT. Verdict holds its value across cycles with no request.
- R3: For class 0 (state save) or class 1 (state restore) with saveRestoreEn = 0, the verdict is UD_FAULT, whatever the masks hold.
- R4: For class 0 or class 1 with saveRestoreEn = 1, the verdict is VM_EXIT if any bit position is 1 in all three of reqMask, supState and exitBitmap, and NORMAL otherwise. Both classes use the same rule.
- R5: For class 3 (external interrupt) with extIntExitEn = 1, intBlockedOther = 0 and no blocking shadow, the verdict is VM_EXIT whatever intEnFlag is. With extIntExitEn = 0 or intBlockedOther = 1, the verdict is NORMAL.
- R6: With the default parameters (shadow blocks both kinds), shadowActive = 1 turns a class 3 or class 4 request that would otherwise exit into NORMAL.
- R7: For class 4 (NMI), the verdict is VM_EXIT when nmiExitEn = 1 and no blocking shadow is present, and NORMAL when nmiExitEn = 0.
- R8: For class 2 (task switch) through a gate (gateUsed = 1) whose gatePresent = 0, the verdict is NP_FAULT. This check comes before every other check.
- R9: For class 2 through a present gate, the verdict is GP_FAULT when longMode = 1 and the access is a call, software interrupt or jump (gateByBranch = 1), or when gatePrivOk = 0.
- R10: A class 2 request that passes every gate check, or that uses no gate (gateUsed = 0), gets VM_EXIT.
- R11: Class codes 5, 6 and 7 get NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| inClass | input | 3 | Request kind: 0 save, 1 restore, 2 task switch, 3 external interrupt, 4 NMI |
| reqMask | input | 64 | Requested-component mask of the save/restore instruction |
| supState | input | 64 | Supervisor-state enable register |
| exitBitmap | input | 64 | Hypervisor exiting bitmap for save/restore |
| saveRestoreEn | input | 1 | Enables the save/restore instructions in the guest |
| extIntExitEn | input | 1 | External-interrupt exiting control |
| nmiExitEn | input | 1 | NMI exiting control |
| intEnFlag | input | 1 | Guest interrupt-enable flag |
| intBlockedOther | input | 1 | External interrupt blocked for reasons other than the enable flag |
| shadowActive | input | 1 | Interrupt shadow after an interrupt-enable or stack-segment load |
| gateUsed | input | 1 | Task switch goes through a task gate |
| gatePresent | input | 1 | Present bit of that gate |
| gatePrivOk | input | 1 | Gate privilege fields pass |
| longMode | input | 1 | Core is in 64-bit long mode |
| gateByBranch | input | 1 | Gate reached by call, software interrupt or jump |
| outValid | output | 1 | One-cycle verdict strobe |
| verdict | output | 5 | One-hot verdict |

## Verification
The bench tests single set bits at both ends of the 64-bit masks, and also masks that overlap in two of the three operands but not the third. A design that used a two-way AND, or that dropped an end chunk of the reduction, would give NORMAL where VM_EXIT is due, or VM_EXIT where NORMAL is due. Task-switch requests combine a missing gate with a privilege failure, so a design with the fault priority reversed would return GP_FAULT instead of NP_FAULT. Interrupt requests arrive with the enable flag clear, so a design that let the flag gate the exit would show NORMAL. Idle cycles and requests held during reset show whether a design leaks a strobe or loses the held verdict.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int VERD_W = 5;

  // one-hot positions of the verdict
  localparam int V_NORMAL = 0;
  localparam int V_UD     = 1;
  localparam int V_GP     = 2;
  localparam int V_NP     = 3;
  localparam int V_EXIT   = 4;

  // request kinds
  localparam logic [2:0] CLS_SAVE    = 3'd0;
  localparam logic [2:0] CLS_RESTORE = 3'd1;
  localparam logic [2:0] CLS_TASKSW  = 3'd2;
  localparam logic [2:0] CLS_EXTINT  = 3'd3;
  localparam logic [2:0] CLS_NMI     = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [VERD_W-1:0] pick;
  } ctlStrobeT;
endpackage

// File: rtl/gid_datapath.sv
module gid_datapath
  import gid_pkg::*;
#(
  parameter int MASK_W  = 64,
  parameter int CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [MASK_W-1:0] supState,
  input  logic [MASK_W-1:0] exitBitmap,
  input  ctlStrobeT         strobe,
  output logic              maskHit,
  output logic              outValid,
  output logic [VERD_W-1:0] verdict
);
  localparam int NCHUNK = MASK_W / CHUNK_W;

  logic [MASK_W-1:0] andVec;
  logic [NCHUNK-1:0] chunkHit;

  assign andVec = reqMask & supState & exitBitmap;

  // two-level OR reduction keeps the depth shallow for wide masks
  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign chunkHit[g] = |andVec[g*CHUNK_W +: CHUNK_W];
  end

  assign maskHit = |chunkHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      verdict  <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        verdict <= strobe.pick;
      end
    end
  end
endmodule

// File: rtl/gid_control.sv
module gid_control
  import gid_pkg::*;
#(
  parameter bit SHADOW_BLOCKS_EXT = 1'b1,
  parameter bit SHADOW_BLOCKS_NMI = 1'b1
) (
  input  logic      inValid,
  input  logic [2:0] inClass,
  input  logic      maskHit,
  input  logic      saveRestoreEn,
  input  logic      extIntExitEn,
  input  logic      nmiExitEn,
  input  logic      intBlockedOther,
  input  logic      shadowActive,
  input  logic      gateUsed,
  input  logic      gatePresent,
  input  logic      gatePrivOk,
  input  logic      longMode,
  input  logic      gateByBranch,
  output ctlStrobeT strobe
);
  int unsigned pickIdx;

  always_comb begin
    pickIdx = V_NORMAL;
    case (inClass)
      CLS_SAVE, CLS_RESTORE: begin
        if (!saveRestoreEn)  pickIdx = V_UD;
        else if (maskHit)    pickIdx = V_EXIT;
        else                 pickIdx = V_NORMAL;
      end
      CLS_TASKSW: begin
        // ordered: presence, then mode/privilege, then unconditional exit
        if (gateUsed && !gatePresent)                      pickIdx = V_NP;
        else if (gateUsed && longMode && gateByBranch)     pickIdx = V_GP;
        else if (gateUsed && !gatePrivOk)                  pickIdx = V_GP;
        else                                               pickIdx = V_EXIT;
      end
      CLS_EXTINT: begin
        if (!extIntExitEn || intBlockedOther)              pickIdx = V_NORMAL;
        else if (shadowActive && SHADOW_BLOCKS_EXT)        pickIdx = V_NORMAL;
        else                                               pickIdx = V_EXIT;
      end
      CLS_NMI: begin
        if (!nmiExitEn)                                    pickIdx = V_NORMAL;
        else if (shadowActive && SHADOW_BLOCKS_NMI)        pickIdx = V_NORMAL;
        else                                               pickIdx = V_EXIT;
      end
      default: pickIdx = V_NORMAL;
    endcase
  end

  always_comb begin
    strobe.load = inValid;
    strobe.pick = '0;
    strobe.pick[pickIdx] = 1'b1;
  end
endmodule

// File: rtl/guest_intercept_decider.sv
module guest_intercept_decider
  import gid_pkg::*;
#(
  parameter int MASK_W            = 64,
  parameter int CHUNK_W           = 8,
  parameter bit SHADOW_BLOCKS_EXT = 1'b1,
  parameter bit SHADOW_BLOCKS_NMI = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        inClass,
  input  logic [MASK_W-1:0] reqMask,
  input  logic [MASK_W-1:0] supState,
  input  logic [MASK_W-1:0] exitBitmap,
  input  logic              saveRestoreEn,
  input  logic              extIntExitEn,
  input  logic              nmiExitEn,
  input  logic              intEnFlag,
  input  logic              intBlockedOther,
  input  logic              shadowActive,
  input  logic              gateUsed,
  input  logic              gatePresent,
  input  logic              gatePrivOk,
  input  logic              longMode,
  input  logic              gateByBranch,
  output logic              outValid,
  output logic [VERD_W-1:0] verdict
);
  ctlStrobeT strobe;
  logic      maskHit;
  logic      flagSeen;

  // the guest enable flag never steers an exit decision
  assign flagSeen = intEnFlag;

  gid_control #(
    .SHADOW_BLOCKS_EXT(SHADOW_BLOCKS_EXT),
    .SHADOW_BLOCKS_NMI(SHADOW_BLOCKS_NMI)
  ) ctl_i (
    .inValid(inValid), .inClass(inClass), .maskHit(maskHit),
    .saveRestoreEn(saveRestoreEn), .extIntExitEn(extIntExitEn),
    .nmiExitEn(nmiExitEn), .intBlockedOther(intBlockedOther),
    .shadowActive(shadowActive), .gateUsed(gateUsed),
    .gatePresent(gatePresent), .gatePrivOk(gatePrivOk),
    .longMode(longMode), .gateByBranch(gateByBranch),
    .strobe(strobe)
  );

  gid_datapath #(.MASK_W(MASK_W), .CHUNK_W(CHUNK_W)) dp_i (
    .clk(clk), .rstN(rstN), .reqMask(reqMask), .supState(supState),
    .exitBitmap(exitBitmap), .strobe(strobe), .maskHit(maskHit),
    .outValid(outValid), .verdict(verdict)
  );

  gid_checker #(.MASK_W(MASK_W)) chk_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
    .reqMask(reqMask), .supState(supState), .exitBitmap(exitBitmap),
    .saveRestoreEn(saveRestoreEn), .extIntExitEn(extIntExitEn),
    .intEnFlag(flagSeen), .intBlockedOther(intBlockedOther),
    .shadowActive(shadowActive), .gateUsed(gateUsed),
    .gatePresent(gatePresent), .outValid(outValid), .verdict(verdict)
  );
endmodule

// File: rtl/gid_checker.sv
module gid_checker #(
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        inClass,
  input logic [MASK_W-1:0] reqMask,
  input logic [MASK_W-1:0] supState,
  input logic [MASK_W-1:0] exitBitmap,
  input logic              saveRestoreEn,
  input logic              extIntExitEn,
  input logic              intEnFlag,
  input logic              intBlockedOther,
  input logic              shadowActive,
  input logic              gateUsed,
  input logic              gatePresent,
  input logic              outValid,
  input logic [4:0]        verdict
);
  // R1: outputs quiet while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (outValid == 1'b0 && verdict == 5'b00000);
    end
  end

  a_r2_pulse: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $countones(verdict) == 1);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(verdict));

  a_r3_undef: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inClass == 3'd0 || inClass == 3'd1) && !saveRestoreEn)
    |=> verdict == 5'b00010);

  a_r4_exit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inClass == 3'd0 || inClass == 3'd1) && saveRestoreEn
     && ((reqMask & supState & exitBitmap) != '0))
    |=> verdict == 5'b10000);

  a_r5_flag_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass == 3'd3 && extIntExitEn && !intBlockedOther
     && !shadowActive && !intEnFlag)
    |=> verdict == 5'b10000);

  a_r8_not_present: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass == 3'd2 && gateUsed && !gatePresent)
    |=> verdict == 5'b01000);
endmodule

// File: tb/guest_intercept_decider_tb.sv
`timescale 1ns/1ps
module guest_intercept_decider_tb_top;
  localparam bit SHB_EXT = 1'b1;
  localparam bit SHB_NMI = 1'b1;
  localparam logic [4:0] VN = 5'b00001, VUD = 5'b00010, VGP = 5'b00100,
                         VNP = 5'b01000, VEX = 5'b10000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, inValid, saveRestoreEn, extIntExitEn, nmiExitEn, intEnFlag;
  logic intBlockedOther, shadowActive, gateUsed, gatePresent, gatePrivOk;
  logic longMode, gateByBranch, outValid;
  logic [2:0] inClass;
  logic [63:0] reqMask, supState, exitBitmap;
  logic [4:0] verdict;

  guest_intercept_decider #(.SHADOW_BLOCKS_EXT(SHB_EXT), .SHADOW_BLOCKS_NMI(SHB_NMI)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
    .reqMask(reqMask), .supState(supState), .exitBitmap(exitBitmap),
    .saveRestoreEn(saveRestoreEn), .extIntExitEn(extIntExitEn),
    .nmiExitEn(nmiExitEn), .intEnFlag(intEnFlag),
    .intBlockedOther(intBlockedOther), .shadowActive(shadowActive),
    .gateUsed(gateUsed), .gatePresent(gatePresent), .gatePrivOk(gatePrivOk),
    .longMode(longMode), .gateByBranch(gateByBranch),
    .outValid(outValid), .verdict(verdict));

  int nVec = 0, nBad = 0;
  logic expValid = 1'b0;
  logic [4:0] expVerd = 5'b0;
  string expTag = "R1";

  // behavioural reference of the requirements
  function automatic logic [4:0] refModel(output string tag);
    bit anyCommon = 1'b0;
    for (int b = 0; b < 64; b++)
      if (reqMask[b] && supState[b] && exitBitmap[b]) anyCommon = 1'b1;
    case (inClass)
      3'd0, 3'd1: begin
        if (!saveRestoreEn) begin tag = "R3"; return VUD; end
        tag = "R4"; return anyCommon ? VEX : VN;
      end
      3'd2: begin
        if (gateUsed && !gatePresent) begin tag = "R8"; return VNP; end
        if (gateUsed && ((longMode && gateByBranch) || !gatePrivOk)) begin tag = "R9"; return VGP; end
        tag = "R10"; return VEX;
      end
      3'd3: begin
        tag = "R5";
        if (!extIntExitEn || intBlockedOther) return VN;
        if (shadowActive && SHB_EXT) begin tag = "R6"; return VN; end
        return VEX;
      end
      3'd4: begin
        tag = "R7";
        if (!nmiExitEn) return VN;
        if (shadowActive && SHB_NMI) begin tag = "R6"; return VN; end
        return VEX;
      end
      default: begin tag = "R11"; return VN; end
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      expValid = 1'b0; expVerd = 5'b0; expTag = "R1";
    end else begin
      expValid = inValid;
      if (inValid) expVerd = refModel(expTag);
      else expTag = "R2";
    end
    @(negedge clk);
    nVec++;
    if (outValid !== expValid || verdict !== expVerd) begin
      nBad++;
      $display("FAIL %s: outValid=%b verdict=%b expected outValid=%b verdict=%b",
               expTag, outValid, verdict, expValid, expVerd);
    end
  endtask

  task automatic clearIn();
    inValid = 0; inClass = 0; reqMask = 0; supState = 0; exitBitmap = 0;
    saveRestoreEn = 0; extIntExitEn = 0; nmiExitEn = 0; intEnFlag = 0;
    intBlockedOther = 0; shadowActive = 0; gateUsed = 0; gatePresent = 0;
    gatePrivOk = 0; longMode = 0; gateByBranch = 0;
  endtask

  task automatic req(input logic [2:0] c);
    inValid = 1'b1; inClass = c; tick(); inValid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL R2: watchdog expired, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    clearIn();
    // R1: request during reset must not produce a strobe
    inValid = 1'b1; inClass = 3'd4; nmiExitEn = 1'b1;
    repeat (3) tick();
    @(negedge clk); rstN = 1'b1; clearIn();
    tick();

    // R3: disabled save/restore faults as undefined
    reqMask = '1; supState = '1; exitBitmap = '1;
    req(3'd0); req(3'd1);
    // R4: exit rule with enable set
    saveRestoreEn = 1'b1;
    req(3'd0);
    reqMask = 64'h8000_0000_0000_0000; exitBitmap = 64'h8000_0000_0000_0000;
    req(3'd1);
    reqMask = 64'h1; exitBitmap = 64'h1; req(3'd0);
    reqMask = 64'h1; supState = 64'h1; exitBitmap = 64'h2; req(3'd1);
    reqMask = 64'hF0; supState = 64'h0F; exitBitmap = 64'hFF; req(3'd0);
    // R2: idle cycles hold verdict
    tick(); tick();
    clearIn();

    // R5: external interrupt, flag clear or set
    extIntExitEn = 1'b1; req(3'd3);
    intEnFlag = 1'b1; req(3'd3);
    intBlockedOther = 1'b1; req(3'd3);
    intBlockedOther = 1'b0; extIntExitEn = 1'b0; req(3'd3);
    // R6: shadow blocks
    extIntExitEn = 1'b1; shadowActive = 1'b1; req(3'd3);
    nmiExitEn = 1'b1; req(3'd4);
    shadowActive = 1'b0;
    // R7
    req(3'd4); nmiExitEn = 1'b0; req(3'd4);
    clearIn();

    // R8: not-present wins over all other failures
    gateUsed = 1'b1; longMode = 1'b1; gateByBranch = 1'b1; req(3'd2);
    // R9
    gatePresent = 1'b1; gatePrivOk = 1'b1; req(3'd2);
    longMode = 1'b0; gatePrivOk = 1'b0; req(3'd2);
    // R10
    gatePrivOk = 1'b1; req(3'd2);
    longMode = 1'b1; gateByBranch = 1'b0; req(3'd2);
    gateUsed = 1'b0; gatePresent = 1'b0; gatePrivOk = 1'b0; req(3'd2);
    // R11
    req(3'd5); req(3'd6); req(3'd7);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      inValid = ($urandom_range(0, 3) != 0);
      inClass = 3'($urandom_range(0, 7));
      reqMask = 64'h1 << $urandom_range(0, 63);
      supState = {$urandom, $urandom};
      exitBitmap = {$urandom, $urandom};
      {saveRestoreEn, extIntExitEn, nmiExitEn, intEnFlag} = 4'($urandom);
      {intBlockedOther, shadowActive, gateUsed, gatePresent} = 4'($urandom);
      {gatePrivOk, longMode, gateByBranch} = 3'($urandom);
      tick();
    end
    clearIn();
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule